// File: doc/BRIEF.md
# Power-Delivery Transmit Request and Alert Controller

This block is the transmit side of a Type-C port controller, as the host port manager sees it over a simple byte-wide register bus. The host first fills a transmit buffer with a byte count and up to 30 message bytes. It then writes a request register that holds a packet-class selector and a retry count. The block passes the buffered message to an abstract PHY. The PHY is driven by a one-cycle start pulse and answers each attempt with either an acknowledge pulse or a timeout pulse. The block starts another attempt after each timeout until the retries run out.

Every request ends in exactly one outcome: success, failure after all attempts, or discard because a message arrived from the line. Each outcome sets its own sticky alert bit. Receive-side events (message received, hard reset received) set two more sticky bits at any time. The host clears alert bits by writing ones to them. A mask register decides which alert bits pull the active-low interrupt line low. A new request is refused while an outcome bit from the previous request is still set.

Register map (byte addresses): 0 alert, 1 mask, 2 request, 3 byte count, 4 to 33 message bytes 0 to 29.

Top module: `pd_tx_alert_ctrl`

## Requirements
- R1: Writes to address 3 (byte count) and addresses 4..33 (message bytes 0..29) are stored and read back unchanged. The PHY sees the count on phy_len_o, and message byte k on phy_rd_data_o when phy_rd_addr_i is k. Both read 0 for a PHY index of 30 or above and for unmapped register addresses.
- R2: A write to address 2 is accepted when the sequencer is idle and alert bits 2..4 are all clear. Bits [2:0] are the selector and bits [5:4] are the retry count. The register reads back as those two fields with the other bits zero. In the cycle after acceptance phy_start_o is high for exactly one cycle, and phy_sop_o holds the selector.
- R3: A request makes at most retry count + 1 attempts. A timeout that arrives while attempts remain raises phy_start_o in the following cycle.
- R4: An acknowledge during an attempt sets alert bit 4 (success) on the next edge and ends the request.
- R5: A timeout on the last attempt sets alert bit 2 (failure) on the next edge and ends the request.
- R6: rx_msg_i during the start cycle or while an attempt is waiting ends the request with alert bit 3 (discard). It takes priority over an acknowledge or timeout in the same cycle, and no further start follows.
- R7: rx_msg_i sets alert bit 0 and rx_hard_reset_i sets alert bit 1, in any state. A hard reset does not end a running request.
- R8: Writing a 1 to an alert bit at address 0 clears it, and writing a 0 leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R9: A request write while an outcome bit is set, or while a request is running, is ignored. It produces no start, leaves the request register unchanged and changes no alert bit.
- R10: The mask at address 1 uses the same bit positions as the alert register (1 = enabled). alert_n_o is low exactly when some alert bit and its mask bit are both set. Masked bits still latch.
- R11: After reset the alert bits are 0, the mask is 0x1F, the buffer and request register are 0, the sequencer is idle and alert_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (6) | Register address |
| reg_wdata_i | input | DW (8) | Register write data |
| reg_rdata_o | output | DW (8) | Register read data for reg_addr_i (combinational) |
| phy_start_o | output | 1 | One-cycle pulse that starts a PHY attempt |
| phy_sop_o | output | SOP_W (3) | Packet-class selector of the accepted request |
| phy_ack_i | input | 1 | PHY: acknowledge received for the current attempt |
| phy_timeout_i | input | 1 | PHY: no acknowledge for the current attempt |
| phy_len_o | output | DW (8) | Byte count of the buffered message |
| phy_rd_addr_i | input | MEM_AW (5) | PHY read index into the message bytes |
| phy_rd_data_o | output | DW (8) | Message byte at phy_rd_addr_i |
| rx_msg_i | input | 1 | Pulse: a message arrived from the line |
| rx_hard_reset_i | input | 1 | Pulse: a hard reset arrived from the line |
| alert_n_o | output | 1 | Active-low interrupt |

## Verification
The assertions assume the PHY behaves properly. It raises acknowledge or timeout only while an attempt is waiting, never both in one cycle, and each as a single-cycle pulse after a start. The bench keeps to this with a responder that reacts to each observed start pulse with exactly one response, two edges later. Stray PHY pulses arrive only in idle, where they have no effect. Receive events and register writes are driven freely, including in the start cycle, during waiting, and on the same edge as a clearing write.

// File: rtl/pd_tx_pkg.sv
`timescale 1ns/1ps
package pd_tx_pkg;
  localparam int unsigned ALERT_W    = 5;
  localparam int unsigned AL_RX_MSG  = 0;
  localparam int unsigned AL_RX_HRST = 1;
  localparam int unsigned AL_TX_FAIL = 2;
  localparam int unsigned AL_TX_DISC = 3;
  localparam int unsigned AL_TX_OK   = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic ok;
    logic fail;
    logic disc;
  } tx_done_t;
endpackage

// File: rtl/pd_tx_buffer.sv
`timescale 1ns/1ps
module pd_tx_buffer #(
  parameter  int unsigned DW     = 8,
  parameter  int unsigned BYTES  = 30,
  localparam int unsigned IDX_W  = $clog2(BYTES + 1),
  localparam int unsigned MEM_AW = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [MEM_AW-1:0] phy_addr_i,
  output logic [DW-1:0]     phy_data_o,
  output logic [DW-1:0]     len_o
);
  logic [DW-1:0] len_q;
  logic [DW-1:0] mem_q [BYTES];

  // index 0 is the byte count, index g+1 is message byte g
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       len_q <= '0;
    else if (we_i && idx_i == '0)      len_q <= wdata_i;
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g + 1))      mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    if (idx_i == '0)                   rdata_o = len_q;
    else if (idx_i <= IDX_W'(BYTES))   rdata_o = mem_q[MEM_AW'(idx_i - IDX_W'(1))];
    else                               rdata_o = '0;
  end

  assign phy_data_o = ({1'b0, phy_addr_i} < (MEM_AW + 1)'(BYTES)) ? mem_q[phy_addr_i] : '0;
  assign len_o      = len_q;

  AST_LEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && idx_i == '0) |=> $stable(len_o)) else $error("len changed without write"); // R1
endmodule

// File: rtl/pd_tx_seq.sv
`timescale 1ns/1ps
module pd_tx_seq
  import pd_tx_pkg::*;
#(
  parameter int unsigned SOP_W   = 3,
  parameter int unsigned RETRY_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_req_i,
  input  logic [SOP_W-1:0]   sop_i,
  input  logic [RETRY_W-1:0] retry_i,
  input  logic               phy_ack_i,
  input  logic               phy_timeout_i,
  input  logic               rx_msg_i,
  output logic               phy_start_o,
  output logic [SOP_W-1:0]   phy_sop_o,
  output logic               busy_o,
  output tx_done_t           done_o
);
  seq_state_e         state_q, state_d;
  logic [RETRY_W-1:0] left_q, left_d;
  logic [SOP_W-1:0]   sop_q;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    done_o  = '0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_req_i) begin
          state_d = SEQ_START;
          left_d  = retry_i;
        end
      end
      SEQ_START: begin
        if (rx_msg_i) begin
          done_o.disc = 1'b1;
          state_d     = SEQ_IDLE;
        end else begin
          state_d = SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        // incoming traffic outranks any PHY answer
        if (rx_msg_i) begin
          done_o.disc = 1'b1;
          state_d     = SEQ_IDLE;
        end else if (phy_ack_i) begin
          done_o.ok = 1'b1;
          state_d   = SEQ_IDLE;
        end else if (phy_timeout_i) begin
          if (left_q == '0) begin
            done_o.fail = 1'b1;
            state_d     = SEQ_IDLE;
          end else begin
            left_d  = left_q - RETRY_W'(1);
            state_d = SEQ_START;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      left_q  <= '0;
      sop_q   <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      if (state_q == SEQ_IDLE && start_req_i) sop_q <= sop_i;
    end
  end

  assign phy_start_o = (state_q == SEQ_START);
  assign phy_sop_o   = sop_q;
  assign busy_o      = (state_q != SEQ_IDLE);

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_start_o |=> !phy_start_o) else $error("start longer than one cycle"); // R2
  AST_RETRY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_WAIT && phy_timeout_i && !phy_ack_i && !rx_msg_i && left_q != '0)
      |=> phy_start_o) else $error("retry not started"); // R3
  AST_ACK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_WAIT && phy_ack_i && !rx_msg_i) |=> !busy_o) else $error("ack did not end"); // R4
  AST_DISCARD_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rx_msg_i) |=> (!busy_o && !phy_start_o)) else $error("discard did not end"); // R6
  AST_SOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(phy_sop_o)) else $error("selector changed while busy"); // R9
endmodule

// File: rtl/pd_alert_reg.sv
`timescale 1ns/1ps
module pd_alert_reg
  import pd_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ALERT_W-1:0] set_i,
  input  logic [ALERT_W-1:0] clr_i,
  input  logic               mask_we_i,
  input  logic [ALERT_W-1:0] mask_i,
  output logic [ALERT_W-1:0] alert_o,
  output logic [ALERT_W-1:0] mask_o,
  output logic               alert_n_o
);
  logic [ALERT_W-1:0] alert_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alert_q <= '0;
      mask_q  <= '1;
    end else begin
      alert_q <= (alert_q & ~clr_i) | set_i;  // set wins over clear
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign alert_o   = alert_q;
  assign mask_o    = mask_q;
  assign alert_n_o = ~|(alert_q & mask_q);

  AST_W1C_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|alert_q) |=> (($past(alert_q) & ~$past(clr_i) & ~alert_q) == '0))
    else $error("uncleared bit dropped"); // R8
  AST_SET_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((alert_q & $past(set_i)) == $past(set_i)))
    else $error("event not latched"); // R7
endmodule

// File: rtl/pd_tx_alert_ctrl.sv
`timescale 1ns/1ps
module pd_tx_alert_ctrl
  import pd_tx_pkg::*;
#(
  parameter  int unsigned DW        = 8,
  parameter  int unsigned BUF_BYTES = 30,
  parameter  int unsigned SOP_W     = 3,
  parameter  int unsigned RETRY_W   = 2,
  localparam int unsigned ADDR_W    = $clog2(BUF_BYTES + 4),
  localparam int unsigned MEM_AW    = $clog2(BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              phy_start_o,
  output logic [SOP_W-1:0]  phy_sop_o,
  input  logic              phy_ack_i,
  input  logic              phy_timeout_i,
  output logic [DW-1:0]     phy_len_o,
  input  logic [MEM_AW-1:0] phy_rd_addr_i,
  output logic [DW-1:0]     phy_rd_data_o,
  input  logic              rx_msg_i,
  input  logic              rx_hard_reset_i,
  output logic              alert_n_o
);
  localparam int unsigned IDX_W     = $clog2(BUF_BYTES + 1);
  localparam int unsigned ADR_ALERT = 0;
  localparam int unsigned ADR_MASK  = 1;
  localparam int unsigned ADR_REQ   = 2;
  localparam int unsigned ADR_BUF   = 3;
  localparam int unsigned RETRY_LSB = 4;

  logic               wr_alert, wr_mask, wr_req, wr_buf, in_buf;
  logic [ADDR_W-1:0]  buf_off;
  logic [IDX_W-1:0]   buf_idx;
  logic [DW-1:0]      buf_rdata;
  logic [ALERT_W-1:0] alert, mask, alert_set, alert_clr;
  logic               outcome_pend, busy, start_req;
  logic [SOP_W-1:0]   req_sop_q;
  logic [RETRY_W-1:0] req_retry_q;
  tx_done_t           done;

  assign buf_off  = reg_addr_i - ADDR_W'(ADR_BUF);
  assign in_buf   = (reg_addr_i >= ADDR_W'(ADR_BUF)) && (buf_off <= ADDR_W'(BUF_BYTES));
  assign buf_idx  = buf_off[IDX_W-1:0];
  assign wr_alert = reg_we_i && (reg_addr_i == ADDR_W'(ADR_ALERT));
  assign wr_mask  = reg_we_i && (reg_addr_i == ADDR_W'(ADR_MASK));
  assign wr_req   = reg_we_i && (reg_addr_i == ADDR_W'(ADR_REQ));
  assign wr_buf   = reg_we_i && in_buf;

  assign outcome_pend = alert[AL_TX_FAIL] | alert[AL_TX_DISC] | alert[AL_TX_OK];
  assign start_req    = wr_req && !busy && !outcome_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sop_q   <= '0;
      req_retry_q <= '0;
    end else if (start_req) begin
      req_sop_q   <= reg_wdata_i[SOP_W-1:0];
      req_retry_q <= reg_wdata_i[RETRY_LSB +: RETRY_W];
    end
  end

  pd_tx_buffer #(.DW(DW), .BYTES(BUF_BYTES)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_buf),
    .idx_i      (buf_idx),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (buf_rdata),
    .phy_addr_i (phy_rd_addr_i),
    .phy_data_o (phy_rd_data_o),
    .len_o      (phy_len_o)
  );

  pd_tx_seq #(.SOP_W(SOP_W), .RETRY_W(RETRY_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_req_i   (start_req),
    .sop_i         (reg_wdata_i[SOP_W-1:0]),
    .retry_i       (reg_wdata_i[RETRY_LSB +: RETRY_W]),
    .phy_ack_i     (phy_ack_i),
    .phy_timeout_i (phy_timeout_i),
    .rx_msg_i      (rx_msg_i),
    .phy_start_o   (phy_start_o),
    .phy_sop_o     (phy_sop_o),
    .busy_o        (busy),
    .done_o        (done)
  );

  always_comb begin
    alert_set             = '0;
    alert_set[AL_RX_MSG]  = rx_msg_i;
    alert_set[AL_RX_HRST] = rx_hard_reset_i;
    alert_set[AL_TX_FAIL] = done.fail;
    alert_set[AL_TX_DISC] = done.disc;
    alert_set[AL_TX_OK]   = done.ok;
  end
  assign alert_clr = wr_alert ? reg_wdata_i[ALERT_W-1:0] : '0;

  pd_alert_reg u_alert (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (alert_set),
    .clr_i     (alert_clr),
    .mask_we_i (wr_mask),
    .mask_i    (reg_wdata_i[ALERT_W-1:0]),
    .alert_o   (alert),
    .mask_o    (mask),
    .alert_n_o (alert_n_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADR_ALERT))      reg_rdata_o[ALERT_W-1:0] = alert;
    else if (reg_addr_i == ADDR_W'(ADR_MASK))  reg_rdata_o[ALERT_W-1:0] = mask;
    else if (reg_addr_i == ADDR_W'(ADR_REQ)) begin
      reg_rdata_o[SOP_W-1:0]            = req_sop_q;
      reg_rdata_o[RETRY_LSB +: RETRY_W] = req_retry_q;
    end
    else if (in_buf)                           reg_rdata_o = buf_rdata;
  end

  AST_REQ_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && outcome_pend) |=> !phy_start_o) else $error("blocked request started"); // R9
  AST_OUTCOME_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy) |=> !$rose(alert[AL_TX_OK])) else $error("success without request"); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((alert & mask) == '0 && !alert_n_o) |-> 1'b0) else $error("irq without enabled bit"); // R10
endmodule

// File: tb/pd_tx_alert_ctrl_bench.sv
`timescale 1ns/1ps
module pd_tx_alert_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata_o;
  logic       phy_start_o;
  logic [2:0] phy_sop_o;
  logic       phy_ack = 1'b0;
  logic       phy_timeout = 1'b0;
  logic [7:0] phy_len_o;
  logic [4:0] phy_rd_addr = '0;
  logic [7:0] phy_rd_data_o;
  logic       rx_msg = 1'b0;
  logic       rx_hrst = 1'b0;
  logic       alert_n_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pd_tx_alert_ctrl u_pd_tx_alert_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata_o), .phy_start_o(phy_start_o),
    .phy_sop_o(phy_sop_o), .phy_ack_i(phy_ack), .phy_timeout_i(phy_timeout),
    .phy_len_o(phy_len_o), .phy_rd_addr_i(phy_rd_addr), .phy_rd_data_o(phy_rd_data_o),
    .rx_msg_i(rx_msg), .rx_hard_reset_i(rx_hrst), .alert_n_o(alert_n_o)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_alert = 0, m_mask = 31, m_state = 0, m_left = 0, m_sop = 0, m_req = 0;
  int m_buf [NB + 1];
  int m_set, m_clr;
  initial foreach (m_buf[i]) m_buf[i] = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_set = 0;
      m_clr = (reg_we && reg_addr == 0) ? int'(reg_wdata) & 31 : 0;
      if (rx_msg)  m_set |= 1;
      if (rx_hrst) m_set |= 2;
      case (m_state)
        1: if (rx_msg) begin m_set |= 8; m_state = 0; end else m_state = 2;
        2: begin
          if (rx_msg) begin m_set |= 8; m_state = 0; end
          else if (phy_ack) begin m_set |= 16; m_state = 0; end
          else if (phy_timeout) begin
            if (m_left == 0) begin m_set |= 4; m_state = 0; end
            else begin m_left--; m_state = 1; end
          end
        end
        default: if (reg_we && reg_addr == 2 && (m_alert & 28) == 0) begin
          m_state = 1;
          m_left  = (int'(reg_wdata) >> 4) & 3;
          m_sop   = int'(reg_wdata) & 7;
          m_req   = int'(reg_wdata) & 8'h37;
        end
      endcase
      if (reg_we && reg_addr == 1) m_mask = int'(reg_wdata) & 31;
      if (reg_we && reg_addr >= 3 && reg_addr <= 33) m_buf[int'(reg_addr) - 3] = int'(reg_wdata);
      m_alert = (m_alert & ~m_clr) | m_set;
    end
  end

  function automatic int exp_rd(int a);
    if (a == 0) return m_alert;
    if (a == 1) return m_mask;
    if (a == 2) return m_req;
    if (a >= 3 && a <= 33) return m_buf[a - 3];
    return 0;
  endfunction

  function automatic string rd_tag(int a);
    if (a == 0) return "R8 alert readback";
    if (a == 1) return "R10 mask readback";
    if (a == 2) return "R9 request readback";
    return "R1 buffer readback";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      check("R10 alert_n_o", alert_n_o, ((m_alert & m_mask) != 0) ? 0 : 1);
      check("R2 R3 phy_start_o", phy_start_o, (m_state == 1) ? 1 : 0);
      check("R2 phy_sop_o", phy_sop_o, m_sop);
      check("R1 phy_len_o", phy_len_o, m_buf[0]);
      check("R1 phy_rd_data_o", phy_rd_data_o, (phy_rd_addr < NB) ? m_buf[int'(phy_rd_addr) + 1] : 0);
      check(rd_tag(int'(reg_addr)), reg_rdata_o, exp_rd(int'(reg_addr)));
    end
  end

  always @(posedge clk) begin
    #1 phy_rd_addr = phy_rd_addr + 5'd1;
  end

  // ---------------- PHY responder ----------------
  int start_cnt = 0, resp_base = 0, resp_fail = 0;
  bit resp_on = 0, resp_to;
  always begin
    @(negedge clk);
    if (rst_n && phy_start_o) begin
      start_cnt++;
      if (resp_on) begin
        resp_to = (start_cnt - resp_base) <= resp_fail;
        @(posedge clk); #1;
        if (resp_to) phy_timeout = 1'b1; else phy_ack = 1'b1;
        @(posedge clk); #1;
        phy_timeout = 1'b0;
        phy_ack     = 1'b0;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic reg_wr(int a, int d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = 8'(d);
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_chk(string tag, int a, int exp);
    @(posedge clk); #1;
    reg_addr = 6'(a);
    @(negedge clk);
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic pulse_rx(bit hard);
    @(posedge clk); #1;
    if (hard) rx_hrst = 1'b1; else rx_msg = 1'b1;
    @(posedge clk); #1;
    rx_hrst = 1'b0; rx_msg = 1'b0;
  endtask

  task automatic run_tx(string tag, int sop, int retry, int fails, int exp_alert);
    int exp_starts;
    resp_on = 1; resp_base = start_cnt; resp_fail = fails;
    reg_wr(2, (retry << 4) | sop);
    repeat (20) @(posedge clk);
    exp_starts = (fails >= retry + 1) ? retry + 1 : fails + 1;
    check({tag, " R3 attempts"}, start_cnt - resp_base, exp_starts);
    reg_chk({tag, " outcome"}, 0, exp_alert);
    @(negedge clk);
    check({tag, " R10 irq low"}, alert_n_o, 0);
    resp_on = 0;
    reg_wr(0, 31);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    check("R11 alert_n_o after reset", alert_n_o, 1);
    check("R11 no start after reset", phy_start_o, 0);
    reg_chk("R11 alert reset", 0, 0);
    reg_chk("R11 mask reset", 1, 31);
    reg_chk("R11 request reset", 2, 0);
    reg_chk("R11 count reset", 3, 0);

    // R1 buffer fill and readback
    reg_wr(3, 27);
    for (int i = 0; i < NB; i++) reg_wr(4 + i, (i * 37 + 11) & 255);
    reg_chk("R1 count", 3, 27);
    reg_chk("R1 first byte", 4, 11);
    reg_chk("R1 last byte", 33, (29 * 37 + 11) & 255);
    reg_chk("R1 unmapped", 34, 0);
    repeat (34) @(posedge clk);

    // R4 success on first attempt
    run_tx("R4 success", 2, 3, 0, 16);

    // R8 write-zero keeps, R9 blocked while outcome set
    resp_on = 1; resp_base = start_cnt; resp_fail = 0;
    reg_wr(2, 8'h11);
    repeat (8) @(posedge clk);
    reg_chk("R4 pending", 0, 16);
    reg_wr(0, 8'h0F);
    reg_chk("R8 zero write keeps bit", 0, 16);
    base = start_cnt;
    reg_wr(2, 8'h25);
    repeat (6) @(posedge clk);
    check("R9 no start when blocked", start_cnt - base, 0);
    reg_chk("R9 request unchanged", 2, 8'h11);
    reg_chk("R9 alert unchanged", 0, 16);
    reg_wr(0, 16);
    reg_chk("R8 one clears", 0, 0);
    resp_on = 0;

    // R5 failure after all attempts, R3 retry then success
    run_tx("R5 failure", 3, 2, 99, 4);
    run_tx("R3 late success", 1, 3, 2, 16);
    run_tx("R5 no retry", 4, 0, 9, 4);

    // R6 discard while waiting; R9 request while busy
    base = start_cnt;
    reg_wr(2, 8'h31);
    repeat (2) @(posedge clk);
    reg_wr(2, 8'h04);
    reg_chk("R9 busy request ignored", 2, 8'h31);
    pulse_rx(0);
    repeat (3) @(posedge clk);
    check("R6 single start", start_cnt - base, 1);
    reg_chk("R6 R7 discard outcome", 0, 9);
    reg_wr(0, 31);

    // R6 discard in the start cycle
    base = start_cnt;
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 6'd2; reg_wdata = 8'h12;
    @(posedge clk); #1;
    reg_we = 1'b0; rx_msg = 1'b1;
    @(posedge clk); #1;
    rx_msg = 1'b0;
    repeat (4) @(posedge clk);
    check("R6 start cycle discard", start_cnt - base, 1);
    reg_chk("R6 start cycle outcome", 0, 9);
    reg_wr(0, 31);

    // R7 hard reset does not end request, idle rx sets only status
    reg_wr(2, 8'h00);
    pulse_rx(1);
    repeat (3) @(posedge clk);
    reg_chk("R7 hard reset bit", 0, 2);
    pulse_rx(0);
    reg_chk("R7 R6 end by message", 0, 11);
    reg_wr(0, 31);
    pulse_rx(0);
    reg_chk("R7 idle message", 0, 1);
    reg_wr(0, 31);

    // R8 set wins over same-cycle clear
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 6'd0; reg_wdata = 8'h01; rx_msg = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0; rx_msg = 1'b0;
    reg_chk("R8 set wins", 0, 1);
    reg_wr(0, 31);

    // R10 mask
    reg_wr(1, 8'h01);
    pulse_rx(1);
    reg_chk("R10 masked bit latches", 0, 2);
    @(negedge clk);
    check("R10 masked irq high", alert_n_o, 1);
    pulse_rx(0);
    @(negedge clk);
    check("R10 enabled irq low", alert_n_o, 0);
    reg_wr(0, 31);
    reg_wr(1, 31);
    @(negedge clk);
    check("R10 irq released", alert_n_o, 1);

    repeat (5) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule